// File: doc/BRIEF.md
# Single-Channel Memory-Mapped DMA Engine

This block is one DMA channel. It copies a run of elements from a source region to a destination region through a single-beat bus master port. Each element is one read followed by one write. A software start pulse turns the channel on. The channel turns itself off when the programmed number of elements has been moved, unless hardware-paced circular operation keeps it running.

Pacing has two modes. In software mode the channel runs back to back until it is done. In hardware mode every element waits for the attached peripheral's request line. That line is sampled either as a level or as a rising edge. The peripheral gets a one-clock acknowledge after each completed write. Each address is not a running pointer. It is formed as start + index × increment-enable × element bytes, so a cleared increment enable pins the address to a fixed location, such as a peripheral data register.

Top module: `dma_chan_top`

## Requirements
- R1: A `swStart` pulse while the channel is idle raises `chanOn` at the next clock edge. `chanOn` drops by itself once the element index equals `xferLen`, except during hardware-paced circular operation.
- R2: With `hwTrig`=0 the channel moves exactly `xferLen` elements without waiting for `perReq`.
- R3: For element k (counted from 0), the read address is `srcStart` + k·B if `srcInc`=1 and `srcStart` if `srcInc`=0. The write address is formed the same way from `dstStart` and `dstInc`. B is 1, 2 or 4 bytes for `busWidth` 0, 1 or 2, and code 3 is treated as 4 bytes. `busSize` carries the same code, with 3 mapped to 2.
- R4: Each element is a read (`busWrite`=0) whose accepted `busRdata` is then written (`busWrite`=1) as `busWdata`. A request holds its address and direction until `busReady`.
- R5: With `hwTrig`=1 and `edgeSense`=0, an element starts only while `perReq` is high. The cycle in which `perAck` is high never starts one.
- R6: With `hwTrig`=1 and `edgeSense`=1, each element needs a fresh 0-to-1 transition of `perReq`. A request that is already high when the channel starts does not count.
- R7: With `hwTrig`=1 and `circular`=1, reaching the length restarts from index 0 at the start addresses and keeps `chanOn` high. With `hwTrig`=0 the channel stops at the length whatever `circular` says.
- R8: `perAck` is high for exactly one clock, in the cycle after each write is accepted.
- R9: An `xferLen` of 0 finishes with no bus access and clears `chanOn`.
- R10: A `swStop` pulse clears `chanOn` at once. An element already on the bus completes, and no further element starts.
- R11: `swStart` while the channel is running is ignored: the index and the remaining count are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swStart | input | 1 | Start pulse (turns channel on) |
| swStop | input | 1 | Abort pulse (turns channel off) |
| hwTrig | input | 1 | 0: software pacing, 1: peripheral request pacing |
| edgeSense | input | 1 | 0: level request, 1: rising-edge request |
| srcInc | input | 1 | Source address advances per element |
| dstInc | input | 1 | Destination address advances per element |
| busWidth | input | 2 | Element size code: 0=8, 1=16, 2/3=32 bits |
| circular | input | 1 | Restart at length in hardware pacing |
| srcStart | input | AW | Source start address |
| dstStart | input | AW | Destination start address |
| xferLen | input | LW | Number of elements |
| perReq | input | 1 | Peripheral request |
| perAck | output | 1 | One-clock acknowledge per completed write |
| chanOn | output | 1 | Channel enabled / busy, self-clearing |
| busValid | output | 1 | Bus request valid |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Bus byte address |
| busSize | output | 2 | Bus transfer size code |
| busWdata | output | DW | Write data |
| busReady | input | 1 | Bus accepts the current beat |
| busRdata | input | DW | Read data, valid with busReady on a read |

## Verification
`chanOn` rises one edge after the start pulse. In software mode the first read appears one edge later, because the channel first passes through a decision cycle. The write follows the accepted read on the next edge, and `perAck` follows the accepted write by one edge. An edge-sensed request is registered first, so it starts an element two edges after the rise. The bench changes inputs and samples outputs on the falling edge. It records bus beats and acknowledges at rising edges, and it waits for `chanOn` to fall, with a bounded wait, before comparing counts and logged addresses and data against values computed from the start address, index and element size.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic latchData;
  } dpStrobe_t;
endpackage

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          srcInc,
  input  logic          dstInc,
  input  logic [1:0]    busWidth,
  input  logic [AW-1:0] srcStart,
  input  logic [AW-1:0] dstStart,
  input  logic [LW-1:0] xferLen,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [DW-1:0] wrData,
  output logic [1:0]    sizeCode,
  output logic          atEnd,
  output logic          lenZero
);
  logic [LW-1:0] idxQ;
  logic [DW-1:0] dataQ;
  logic [AW-1:0] stepOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.clrIdx)        idxQ <= '0;
      else if (strobe.incIdx)   idxQ <= idxQ + 1'b1;
      if (strobe.latchData)     dataQ <= busRdata;
    end
  end

  // element size: code 3 behaves as 32-bit
  always_comb begin
    sizeCode = (busWidth == 2'b11) ? 2'd2 : busWidth;
    stepOff  = AW'(idxQ) << sizeCode;
    srcAddr  = srcStart + (srcInc ? stepOff : '0);
    dstAddr  = dstStart + (dstInc ? stepOff : '0);
    wrData   = dataQ;
    atEnd    = (idxQ == xferLen);
    lenZero  = (xferLen == '0);
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      swStart,
  input  logic      swStop,
  input  logic      hwTrig,
  input  logic      edgeSense,
  input  logic      circular,
  input  logic      perReq,
  input  logic      busReady,
  input  logic      atEnd,
  input  logic      lenZero,
  output dpStrobe_t strobe,
  output logic      chanOn,
  output logic      perAck,
  output logic      busValid,
  output logic      busWrite
);
  chanState_t stateQ, stateD;
  logic reqHistQ, edgePendQ;
  logic startNow, keepGoing, trigOk, goRead, restart, finish, riseSeen;

  always_comb begin
    startNow  = (stateQ == ST_IDLE) && swStart;
    keepGoing = chanOn && !swStop;
    riseSeen  = perReq && !reqHistQ;
    if (!hwTrig)        trigOk = 1'b1;
    else if (edgeSense) trigOk = edgePendQ;
    else                trigOk = perReq && !perAck;   // blocked during ack cycle
    restart = (stateQ == ST_CHECK) && keepGoing && atEnd && hwTrig && circular && !lenZero;
    finish  = (stateQ == ST_CHECK) && keepGoing && atEnd && !restart;
    goRead  = (stateQ == ST_CHECK) && keepGoing && !atEnd && trigOk;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (startNow) begin
        stateD        = ST_CHECK;
        strobe.clrIdx = 1'b1;
      end
      ST_CHECK: begin
        if (!keepGoing || finish) stateD = ST_IDLE;
        else if (restart)         strobe.clrIdx = 1'b1;
        else if (goRead)          stateD = ST_READ;
      end
      ST_READ: if (busReady) begin
        stateD           = ST_WRITE;
        strobe.latchData = 1'b1;
      end
      ST_WRITE: if (busReady) begin
        stateD        = ST_CHECK;
        strobe.incIdx = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      chanOn    <= 1'b0;
      perAck    <= 1'b0;
      reqHistQ  <= 1'b0;
      edgePendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      perAck <= (stateQ == ST_WRITE) && busReady;
      if (startNow)    chanOn <= 1'b1;
      else if (swStop) chanOn <= 1'b0;
      else if (finish) chanOn <= 1'b0;
      // history loads the live level at start so a held request is no edge
      reqHistQ <= perReq;
      if (startNow)      edgePendQ <= 1'b0;
      else if (goRead)   edgePendQ <= 1'b0;
      else if (chanOn && riseSeen) edgePendQ <= 1'b1;
    end
  end

  always_comb begin
    busValid = (stateQ == ST_READ) || (stateQ == ST_WRITE);
    busWrite = (stateQ == ST_WRITE);
  end
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          swStart,
  input  logic          swStop,
  input  logic          hwTrig,
  input  logic          edgeSense,
  input  logic          srcInc,
  input  logic          dstInc,
  input  logic [1:0]    busWidth,
  input  logic          circular,
  input  logic [AW-1:0] srcStart,
  input  logic [AW-1:0] dstStart,
  input  logic [LW-1:0] xferLen,
  input  logic          perReq,
  output logic          perAck,
  output logic          chanOn,
  output logic          busValid,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize,
  output logic [DW-1:0] busWdata,
  input  logic          busReady,
  input  logic [DW-1:0] busRdata
);
  dpStrobe_t     strobe;
  logic [AW-1:0] srcAddr, dstAddr;
  logic          atEnd, lenZero;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .swStop(swStop),
    .hwTrig(hwTrig), .edgeSense(edgeSense), .circular(circular),
    .perReq(perReq), .busReady(busReady), .atEnd(atEnd), .lenZero(lenZero),
    .strobe(strobe), .chanOn(chanOn), .perAck(perAck),
    .busValid(busValid), .busWrite(busWrite)
  );

  dma_chan_dpath #(.AW(AW), .DW(DW), .LW(LW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcInc(srcInc), .dstInc(dstInc),
    .busWidth(busWidth), .srcStart(srcStart), .dstStart(dstStart),
    .xferLen(xferLen), .busRdata(busRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .wrData(busWdata), .sizeCode(busSize), .atEnd(atEnd), .lenZero(lenZero)
  );

  assign busAddr = busWrite ? dstAddr : srcAddr;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          chanOn,
  input logic          perAck,
  input logic          busValid,
  input logic          busWrite,
  input logic          busReady,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic [DW-1:0] busRdata
);
  logic [DW-1:0] lastRead;

  always_ff @(posedge clk) begin
    if (!rstN) lastRead <= '0;
    else if (busValid && !busWrite && busReady) lastRead <= busRdata;
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck); // R8
  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> $past(busValid && busWrite && busReady)); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWrite))); // R4
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busReady) |=> (busValid && busWrite)); // R4
  AST_WDATA_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> (busWdata == lastRead)); // R4
  AST_READ_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busValid) && !busWrite) |-> $past(chanOn)); // R10
endmodule

bind dma_chan_top dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .chanOn(chanOn), .perAck(perAck),
  .busValid(busValid), .busWrite(busWrite), .busReady(busReady),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
);

// File: tb/dma_chan_top_tb.sv
`timescale 1ns/1ps
module dma_chan_top_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam logic [AW-1:0] SRC = 32'h0000_1000;
  localparam logic [AW-1:0] DST = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swStart = 0, swStop = 0, hwTrig = 0, edgeSense = 0;
  logic srcInc = 0, dstInc = 0, circular = 0, perReq = 0;
  logic [1:0] busWidth = 0;
  logic [AW-1:0] srcStart = SRC, dstStart = DST;
  logic [LW-1:0] xferLen = 0;
  logic perAck, chanOn, busValid, busWrite, busReady;
  logic [AW-1:0] busAddr;
  logic [1:0] busSize;
  logic [DW-1:0] busWdata, busRdata;

  int compared = 0, mismatched = 0;
  int wrCount = 0, rdCount = 0, ackCount = 0;
  logic [AW-1:0] wrAddrLog [0:1023];
  logic [DW-1:0] wrDataLog [0:1023];
  logic [2:0] stallCnt = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    return a * 32'h0000_9E37 + 32'h1234_5678;
  endfunction

  assign busReady = (stallCnt != 3'd5);
  assign busRdata = memFn(busAddr);

  dma_chan_top #(.AW(AW), .DW(DW), .LW(LW)) dut_i (
    .clk(clk), .rstN(rstN), .swStart(swStart), .swStop(swStop), .hwTrig(hwTrig),
    .edgeSense(edgeSense), .srcInc(srcInc), .dstInc(dstInc), .busWidth(busWidth),
    .circular(circular), .srcStart(srcStart), .dstStart(dstStart), .xferLen(xferLen),
    .perReq(perReq), .perAck(perAck), .chanOn(chanOn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata)
  );

  always @(posedge clk) begin
    stallCnt <= stallCnt + 3'd1;
    if (rstN && busValid && busReady && busWrite) begin
      wrAddrLog[wrCount % 1024] <= busAddr;
      wrDataLog[wrCount % 1024] <= busWdata;
      wrCount <= wrCount + 1;
    end
    if (rstN && busValid && busReady && !busWrite) rdCount <= rdCount + 1;
    if (rstN && perAck) ackCount <= ackCount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    swStart = 1'b1; @(negedge clk); swStart = 1'b0;
  endtask

  task automatic pulseStop();
    swStop = 1'b1; @(negedge clk); swStop = 1'b0;
  endtask

  task automatic waitIdle(input int limit);
    for (int i = 0; i < limit && chanOn; i++) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] base, input bit inc,
                                             input int k, input logic [1:0] w);
    logic [1:0] s;
    s = (w == 2'b11) ? 2'd2 : w;
    return base + (inc ? (AW'(k) << s) : '0);
  endfunction

  task automatic runSweepCase(input logic [1:0] w, input bit si, input bit di,
                              input int len, input bit circ);
    int wb, rb, ab;
    busWidth = w; srcInc = si; dstInc = di; circular = circ;
    hwTrig = 0; edgeSense = 0; xferLen = LW'(len);
    wb = wrCount; rb = rdCount; ab = ackCount;
    pulseStart();
    check(chanOn === 1'b1, "R1", "chanOn after start", 32'(chanOn), 1);
    waitIdle(200);
    check(chanOn === 1'b0, "R1", "chanOn self-clear", 32'(chanOn), 0);
    check(wrCount - wb == len, (len == 0) ? "R9" : "R2", "write count", wrCount - wb, len);
    check(rdCount - rb == len, (len == 0) ? "R9" : "R7", "read count", rdCount - rb, len);
    check(ackCount - ab == len, "R8", "ack count", ackCount - ab, len);
    for (int k = 0; k < len; k++) begin
      logic [AW-1:0] ea, es;
      ea = expAddr(DST, di, k, w);
      es = expAddr(SRC, si, k, w);
      check(wrAddrLog[(wb + k) % 1024] === ea, "R3", "write address",
            wrAddrLog[(wb + k) % 1024], ea);
      check(wrDataLog[(wb + k) % 1024] === memFn(es), "R4", "write data",
            wrDataLog[(wb + k) % 1024], memFn(es));
    end
  endtask

  initial begin
    int wb, n1, n2;
    repeat (3) @(negedge clk);
    check(chanOn === 1'b0 && busValid === 1'b0 && perAck === 1'b0, "R1", "reset state",
          {29'd0, chanOn, busValid, perAck}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // near-exhaustive software-mode sweep (R2, R3, R4, R7, R9)
    for (int w = 0; w < 4; w++)
      for (int inc = 0; inc < 4; inc++)
        for (int len = 0; len < 4; len++)
          runSweepCase(2'(w), inc[0], inc[1], len, len[0]);

    // R11: start pulse mid-run is ignored
    busWidth = 2; srcInc = 1; dstInc = 1; circular = 0; hwTrig = 0; xferLen = 5;
    wb = wrCount;
    pulseStart();
    repeat (6) @(negedge clk);
    pulseStart();
    waitIdle(200);
    check(wrCount - wb == 5, "R11", "count with restart attempt", wrCount - wb, 5);
    for (int k = 0; k < 5; k++)
      check(wrAddrLog[(wb + k) % 1024] === DST + AW'(4 * k), "R11", "address order",
            wrAddrLog[(wb + k) % 1024], DST + AW'(4 * k));

    // R5: level-sensed hardware pacing
    hwTrig = 1; edgeSense = 0; perReq = 0; xferLen = 3; busWidth = 1;
    wb = wrCount; n1 = ackCount;
    pulseStart();
    repeat (15) @(negedge clk);
    check(wrCount - wb == 0, "R5", "no element without request", wrCount - wb, 0);
    check(chanOn === 1'b1, "R5", "waiting channel on", 32'(chanOn), 1);
    perReq = 1;
    waitIdle(200);
    perReq = 0;
    check(wrCount - wb == 3, "R5", "elements with level request", wrCount - wb, 3);
    check(ackCount - n1 == 3, "R8", "acks in hw mode", ackCount - n1, 3);
    check(chanOn === 1'b0, "R1", "hw non-circular stop", 32'(chanOn), 0);

    // R6: edge-sensed pacing, request already high at start
    edgeSense = 1; perReq = 1; xferLen = 2;
    wb = wrCount;
    pulseStart();
    repeat (15) @(negedge clk);
    check(wrCount - wb == 0, "R6", "held request is no edge", wrCount - wb, 0);
    perReq = 0; repeat (2) @(negedge clk); perReq = 1;
    repeat (20) @(negedge clk);
    check(wrCount - wb == 1, "R6", "one element per edge", wrCount - wb, 1);
    perReq = 0; repeat (2) @(negedge clk); perReq = 1;
    waitIdle(200);
    perReq = 0;
    check(wrCount - wb == 2, "R6", "second edge completes", wrCount - wb, 2);
    check(chanOn === 1'b0, "R6", "edge run stop", 32'(chanOn), 0);

    // R7 + R10: circular hardware run, then abort
    edgeSense = 0; circular = 1; xferLen = 2; busWidth = 2; perReq = 1;
    wb = wrCount;
    pulseStart();
    for (int i = 0; i < 300 && (wrCount - wb) < 5; i++) @(negedge clk);
    check(chanOn === 1'b1, "R7", "circular keeps on", 32'(chanOn), 1);
    check(wrCount - wb >= 5, "R7", "circular past length", wrCount - wb, 5);
    pulseStop();
    check(chanOn === 1'b0, "R10", "stop clears on", 32'(chanOn), 0);
    repeat (20) @(negedge clk);
    n1 = wrCount - wb;
    repeat (20) @(negedge clk);
    n2 = wrCount - wb;
    check(n1 == n2, "R10", "no element after stop", n2, n1);
    for (int k = 0; k < n1 && k < 16; k++)
      check(wrAddrLog[(wb + k) % 1024] === DST + AW'(4 * (k % 2)), "R7", "wrap address",
            wrAddrLog[(wb + k) % 1024], DST + AW'(4 * (k % 2)));
    perReq = 0; circular = 0; hwTrig = 0;

    // R10: abort a long software run
    xferLen = 100; wb = wrCount;
    pulseStart();
    repeat (15) @(negedge clk);
    pulseStop();
    repeat (20) @(negedge clk);
    n1 = wrCount - wb;
    repeat (20) @(negedge clk);
    check(n1 > 0 && n1 < 100, "R10", "aborted count", n1, 50);
    check(wrCount - wb == n1, "R10", "count frozen", wrCount - wb, n1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule